// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes interrupt events from a set of peripheral sources and carries out the hardware side of entering a service routine. Each source has a pending flag held inside the block. Each source also has an enable bit supplied by an enable mask input. The block reads the global interrupt enable from a fixed bit of the status word it is given. A request stands when some enabled flag is pending and global enable is set. The sequencer then holds off until the core signals that its current instruction has finished.

After the core signals completion, the block runs a fixed multi-cycle sequence. It pushes the return address, then the status word, through a one-cycle stack memory port. It writes back a reduced status word with global enable cleared and reports the new stack pointer. Next it picks the winning source or group and clears that source's flag if the source is dedicated. Finally it reads the service routine address from the vector table and hands it to the program counter. Sources marked as grouped share one vector. Their flags stay pending until software clears them.

Top module: `int_entry_seq`

## Requirements
- R1: A one-cycle pulse on `evt_i[i]` sets pending flag `i` at the next clock edge, and the flag holds until it is cleared. When a set and a clear hit the same flag in the same cycle, the set wins. A request is accepted only when `flag_o & en_i` is nonzero and status bit `GIE_BIT` (default 3) of `sr_i` is 1. Otherwise `busy_o` stays 0 and no memory access occurs.
- R2: Once a request is accepted, the block makes no memory access and no status or program counter update until a clock edge samples `instr_done_i` high. The values of `pc_i`, `sr_i` and `sp_i` are captured at that edge.
- R3: In the first cycle after the completion edge, the block writes the captured PC to byte address `sp-2`. In the next cycle it writes the captured status word to `sp-4`. Both writes use `mem_req_o=1` and `mem_we_o=1`.
- R4: In the third cycle, `sr_wr_o` pulses and `sr_new_o` equals the captured status word ANDed with `SR_KEEP`, with bit `GIE_BIT` always 0. In the same cycle `sp_we_o` pulses with `sp_o = sp-4`.
- R5: Among the flags pending and enabled in the selection cycle (the fourth), the lowest-numbered source wins.
- R6: At the end of the selection cycle, the winner's flag is cleared if the winner is dedicated, meaning its bit in `GROUPED` is 0. A grouped winner's flag stays set. `flag_clr_i[i]` clears flag `i` at any time.
- R7: In the fifth cycle, the block reads the vector at `VEC_BASE + 2*k` with `mem_we_o=0`. The index `k` is the source number for a dedicated winner, `NSRC` for a grouped winner, and `NSRC+1` if nothing was pending and enabled at selection.
- R8: In the sixth cycle after the completion edge, `pc_load_o` pulses once with `pc_new_o` equal to the word returned on `mem_rdata_i` during the vector read.
- R9: After the load cycle, `busy_o` returns to 0. `busy_o` is 1 from the cycle after a request is accepted through the load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NSRC | Per-source event pulses |
| flag_clr_i | input | NSRC | Software clear of pending flags |
| en_i | input | NSRC | Per-source enable mask |
| instr_done_i | input | 1 | Current instruction completed |
| pc_i | input | DW | Current program counter |
| sr_i | input | DW | Current status word |
| sp_i | input | DW | Current stack pointer |
| mem_req_o | output | 1 | Stack or vector memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | DW | Byte address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid in the access cycle |
| sr_wr_o | output | 1 | Status word update strobe |
| sr_new_o | output | DW | New status word |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_o | output | DW | Stack pointer after both pushes |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_new_o | output | DW | Service routine address |
| busy_o | output | 1 | Entry sequence in progress |
| flag_o | output | NSRC | Pending flags |

## Verification
The hardest case to reach is a request that vanishes between acceptance and selection. That case must produce the spurious vector index. The bench reaches it with a directed case that drops the enable mask to zero on the same edge that samples instruction completion. The flag then stays pending but is no longer enabled when selection runs. Random trials draw event masks, enable masks, PC, status and stack values from a fixed seed. They also vary the delay before the completion strobe. Directed cases cover global enable off, masked-only events, grouped winners and a set colliding with a clear.

// File: rtl/int_entry_seq.sv
module int_entry_seq #(
  parameter int          NSRC     = 8,
  parameter int          DW       = 16,
  parameter logic [7:0]  GROUPED  = 8'hC0,
  parameter logic [15:0] VEC_BASE = 16'hFFC0,
  parameter logic [15:0] SR_KEEP  = 16'h0007,
  parameter int          GIE_BIT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] flag_clr_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            instr_done_i,
  input  logic [DW-1:0]   pc_i,
  input  logic [DW-1:0]   sr_i,
  input  logic [DW-1:0]   sp_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            sr_wr_o,
  output logic [DW-1:0]   sr_new_o,
  output logic            sp_we_o,
  output logic [DW-1:0]   sp_o,
  output logic            pc_load_o,
  output logic [DW-1:0]   pc_new_o,
  output logic            busy_o,
  output logic [NSRC-1:0] flag_o
);
  localparam int IW = $clog2(NSRC + 2);
  localparam logic [DW-1:0] KEEP = DW'(SR_KEEP) & ~(DW'(1) << GIE_BIT);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_PUSH_PC, S_PUSH_SR, S_CLR_SR, S_SELECT, S_FETCH, S_LOAD
  } st_t;

  st_t            st_q;
  logic [NSRC-1:0] flag_q, auto_clr, pend;
  logic [DW-1:0]  pc_q, sr_q, sp_q, vec_q;
  logic [IW-1:0]  vidx_q, vidx_d;
  logic           req;

  assign pend = flag_q & en_i;
  assign req  = (|pend) && sr_i[GIE_BIT];

  always_comb begin
    vidx_d   = IW'(NSRC + 1);
    auto_clr = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vidx_d   = GROUPED[i] ? IW'(NSRC) : IW'(i);
        auto_clr = '0;
        auto_clr[i] = ~GROUPED[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= (flag_q & ~(flag_clr_i | ((st_q == S_SELECT) ? auto_clr : '0))) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pc_q   <= '0;
      sr_q   <= '0;
      sp_q   <= '0;
      vec_q  <= '0;
      vidx_q <= '0;
    end else begin
      case (st_q)
        S_IDLE:    if (req) st_q <= S_WAIT;
        S_WAIT:    if (instr_done_i) begin
                     st_q <= S_PUSH_PC;
                     pc_q <= pc_i;
                     sr_q <= sr_i;
                     sp_q <= sp_i - DW'(2);
                   end
        S_PUSH_PC: begin st_q <= S_PUSH_SR; sp_q <= sp_q - DW'(2); end
        S_PUSH_SR: st_q <= S_CLR_SR;
        S_CLR_SR:  st_q <= S_SELECT;
        S_SELECT:  begin st_q <= S_FETCH; vidx_q <= vidx_d; end
        S_FETCH:   begin st_q <= S_LOAD; vec_q <= mem_rdata_i; end
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == S_PUSH_PC) || (st_q == S_PUSH_SR) || (st_q == S_FETCH);
  assign mem_we_o    = (st_q == S_PUSH_PC) || (st_q == S_PUSH_SR);
  assign mem_addr_o  = (st_q == S_FETCH) ? VEC_BASE + DW'({vidx_q, 1'b0}) : sp_q;
  assign mem_wdata_o = (st_q == S_PUSH_SR) ? sr_q : pc_q;
  assign sr_wr_o     = (st_q == S_CLR_SR);
  assign sr_new_o    = sr_q & KEEP;
  assign sp_we_o     = (st_q == S_CLR_SR);
  assign sp_o        = sp_q;
  assign pc_load_o   = (st_q == S_LOAD);
  assign pc_new_o    = vec_q;
  assign busy_o      = (st_q != S_IDLE);
  assign flag_o      = flag_q;
endmodule

module int_entry_seq_chk #(
  parameter int          NSRC     = 8,
  parameter int          DW       = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFC0,
  parameter int          GIE_BIT  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          sr_wr_o,
  input logic [DW-1:0] sr_new_o,
  input logic          pc_load_o,
  input logic          busy_o
);
  logic [DW-1:0] voff;
  assign voff = mem_addr_o - DW'(VEC_BASE);

  a_r3_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && $past(mem_req_o && mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) - DW'(2));
  a_r4_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_o |-> !sr_new_o[GIE_BIT]);
  a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |-> (voff < DW'(2 * (NSRC + 2)) && !voff[0]));
  a_r8_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !pc_load_o);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(mem_req_o || sr_wr_o || pc_load_o));
  a_r8_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !busy_o);
endmodule

bind int_entry_seq int_entry_seq_chk #(.NSRC(NSRC), .DW(DW), .VEC_BASE(VEC_BASE), .GIE_BIT(GIE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .sr_wr_o(sr_wr_o), .sr_new_o(sr_new_o),
  .pc_load_o(pc_load_o), .busy_o(busy_o));

// File: tb/tb_int_entry_seq.sv
module tb_int_entry_seq;
  localparam int NSRC = 8;
  localparam logic [7:0]  GROUPED  = 8'hC0;
  localparam logic [15:0] VEC_BASE = 16'hFFC0;
  localparam logic [15:0] KEEP     = 16'h0007;

  logic clk = 0, rst_n = 0;
  logic [7:0] evt = 0, fclr = 0, en = 0;
  logic done = 0;
  logic [15:0] pc = 0, sr = 0, sp = 0;
  logic mreq, mwe, srwr, spwe, pcld, busy;
  logic [15:0] maddr, mwd, mrd, srn, spo, pcn;
  logic [7:0] flg;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign mrd = maddr ^ 16'hA5C3;

  int_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .flag_clr_i(fclr), .en_i(en),
    .instr_done_i(done), .pc_i(pc), .sr_i(sr), .sp_i(sp),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_rdata_i(mrd), .sr_wr_o(srwr), .sr_new_o(srn), .sp_we_o(spwe), .sp_o(spo),
    .pc_load_o(pcld), .pc_new_o(pcn), .busy_o(busy), .flag_o(flg));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int vec_idx(input logic [7:0] p);
    for (int i = 0; i < NSRC; i++)
      if (p[i]) return GROUPED[i] ? NSRC : i;
    return NSRC + 1;
  endfunction

  function automatic logic [7:0] after_sel(input logic [7:0] f, input logic [7:0] p);
    for (int i = 0; i < NSRC; i++)
      if (p[i]) return GROUPED[i] ? f : (f & ~(8'd1 << i));
    return f;
  endfunction

  task automatic clear_all();
    @(negedge clk); fclr = 8'hFF;
    @(negedge clk); fclr = 0;
  endtask

  // Full entry: raise events, wait, strobe done, observe six cycles.
  task automatic run_entry(input logic [7:0] ev, input logic [7:0] enm, input int dly, input bit drop_en);
    logic [7:0] fl, pe;
    int k;
    clear_all();
    en = enm; ev = ev;
    @(negedge clk); evt = ev;
    @(negedge clk); evt = 0;
    chk(flg == ev, "R1 flags set", flg, ev);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk(!mreq && !srwr && !pcld, "R2 no access before done", {mreq, srwr, pcld}, 0);
    end
    chk(busy, "R9 busy while waiting", busy, 1);
    done = 1;
    @(posedge clk);
    #1 done = 0;
    if (drop_en) en = 0;
    fl = ev; pe = ev & en;
    k = vec_idx(pe);
    @(negedge clk);
    chk(mreq && mwe && maddr == sp - 2 && mwd == pc, "R3 push pc", {maddr, mwd}, {sp - 16'd2, pc});
    @(negedge clk);
    chk(mreq && mwe && maddr == sp - 4 && mwd == sr, "R3 push sr", {maddr, mwd}, {sp - 16'd4, sr});
    @(negedge clk);
    chk(srwr && srn == (sr & KEEP & ~16'h0008), "R4 sr cleared", srn, sr & KEEP & ~16'h0008);
    chk(spwe && spo == sp - 4, "R4 sp after pushes", spo, sp - 16'd4);
    @(negedge clk);
    chk(!mreq && busy, "R5 select cycle", {mreq, busy}, 1);
    @(negedge clk);
    chk(flg == after_sel(fl, pe), "R6 flag after select", flg, after_sel(fl, pe));
    chk(mreq && !mwe && maddr == VEC_BASE + 16'(2 * k), "R7 vector address", maddr, VEC_BASE + 16'(2 * k));
    @(negedge clk);
    chk(pcld && pcn == ((VEC_BASE + 16'(2 * k)) ^ 16'hA5C3), "R8 pc load", pcn, (VEC_BASE + 16'(2 * k)) ^ 16'hA5C3);
    @(negedge clk);
    chk(!busy && !pcld, "R9 back to idle", {busy, pcld}, 0);
    sr = sr & ~16'h0008;
    clear_all();
    sr = sr | 16'h0008;
  endtask

  task automatic no_entry(input logic [7:0] ev, input logic [7:0] enm, input string req);
    clear_all();
    en = enm;
    @(negedge clk); evt = ev;
    @(negedge clk); evt = 0;
    for (int d = 0; d < 8; d++) begin
      @(negedge clk);
      chk(!busy && !mreq, req, {busy, mreq}, 0);
    end
  endtask

  initial begin
    int seed = 7;
    void'($urandom(seed));
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pc = 16'h1234; sr = 16'h00FF; sp = 16'h0400;
    repeat (3) @(negedge clk);
    chk(!busy && !mreq && flg == 0 && !pcld, "R9 reset state", {busy, flg}, 0);
    rst_n = 1;
    // directed
    run_entry(8'h24, 8'hFF, 3, 0);          // R5 lowest pending wins
    run_entry(8'hC0, 8'hFF, 4, 0);          // R6 grouped stays set
    run_entry(8'h81, 8'h80, 5, 0);          // R5 masked source loses
    run_entry(8'h02, 8'hFF, 3, 1);          // R7 spurious slot
    no_entry(8'h10, 8'hEF, "R1 masked event ignored");
    sr = 16'h00F7;
    no_entry(8'h10, 8'hFF, "R1 global enable off");
    sr = 16'h00FF;
    // R1 set wins over clear in the same cycle
    clear_all();
    en = 0;
    @(negedge clk); evt = 8'h04; fclr = 8'h04;
    @(negedge clk); evt = 0; fclr = 0;
    chk(flg == 8'h04, "R1 set beats clear", flg, 8'h04);
    // random
    for (int t = 0; t < 40; t++) begin
      logic [7:0] ev, em;
      ev = 8'($urandom);
      em = 8'($urandom) | 8'h01;
      if ((ev & em) == 0) ev = ev | 8'h01;
      pc = 16'($urandom);
      sr = 16'($urandom) | 16'h0008;
      sp = 16'($urandom) & 16'hFFFE;
      run_entry(ev, em, 3 + ($urandom % 6), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule